// File: doc/BRIEF.md
# Signed Halfword Divide Unit

A sequential execution unit that divides a signed 32-bit dividend by a signed 16-bit divisor. The divisor is the sign-extended low halfword of a 32-bit source word; the upper halfword of that word plays no part. The unit returns a truncated quotient and a remainder, and it produces write strobes for two destination registers. It also produces the overflow, sign and zero flags, together with one strobe that updates them. No other flag is driven, so any carry or saturation flag held elsewhere keeps its value.

A one-cycle `start_i` pulse captures the operands. The unit also captures the mode inputs: two-operand form, and whether the quotient and remainder destinations are the same register. The division then runs one restoring step per clock on the operand magnitudes. After the last step the signs are corrected and `done_o` pulses, carrying the results and strobes. A zero divisor, and the one quotient that cannot be represented, both raise the overflow flag and block every register write.

Top module: `sdiv_half_unit`

## Requirements
- R1: The divisor is `divisor_src_i[15:0]` taken as signed two's complement; `divisor_src_i[31:16]` has no effect on any output.
- R2: For a legal operation, `quot_o` is the dividend divided by the divisor, rounded toward zero. `rem_o` takes the sign of the dividend, with dividend = quot_o*divisor + rem_o and |rem_o| < |divisor|.
- R3: `done_o` is high for exactly one cycle, 33 clock edges after the edge that accepted `start_i`. `busy_o` is high from the cycle after the accepting edge up to the cycle before `done_o`, and is low while `done_o` is high.
- R4: A `start_i` pulse while `busy_o` is high is ignored: the running operation's results and timing are unchanged.
- R5: A divisor of zero, or a dividend of 0x80000000 with a divisor of -1, gives `ov_o`=1, `s_o`=0 and `z_o`=0 at done. `quot_we_o` and `rem_we_o` stay low, and `quot_o` and `rem_o` keep their previous values.
- R6: For a legal operation, `ov_o`=0 at done, `s_o` equals bit 31 of the quotient, and `z_o`=1 exactly when the quotient is zero.
- R7: Destination strobes at done for a legal operation depend on the mode:
  - `two_op_i`=1: only `quot_we_o` is high.
  - `two_op_i`=0 and `same_dst_i`=0: both strobes are high.
  - `two_op_i`=0 and `same_dst_i`=1: only `rem_we_o` is high.
- R8: `flag_we_o` is high exactly in the `done_o` cycle. `quot_we_o` and `rem_we_o` are never high outside it.
- R9: After reset `busy_o`, `done_o`, `flag_we_o`, `quot_we_o` and `rem_we_o` are low, and `quot_o` and `rem_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the unit is idle |
| dividend_i | input | 32 | Signed dividend |
| divisor_src_i | input | 32 | Source word; low halfword is the signed divisor |
| two_op_i | input | 1 | Two-operand form: no remainder write |
| same_dst_i | input | 1 | Quotient and remainder destinations are the same register |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 32 | Signed quotient |
| rem_o | output | 32 | Signed remainder |
| quot_we_o | output | 1 | Write strobe for the quotient destination |
| rem_we_o | output | 1 | Write strobe for the remainder destination |
| flag_we_o | output | 1 | Update strobe for OV, S and Z |
| ov_o | output | 1 | Overflow flag |
| s_o | output | 1 | Sign flag |
| z_o | output | 1 | Zero flag |

## Verification
Every result, strobe and flag falls due on the 33rd rising edge after the edge that accepted `start_i`. Overflow and divide-by-zero cases take the same latency. The bench drives inputs on falling edges and counts rising edges from the accepting edge. On the falling edge after the 32nd rising edge it checks that `done_o` is still low and `busy_o` is high. On the falling edge after the 33rd it compares outputs against a reference built from signed arithmetic, together with a model of the values held through an overflow. A start injected in mid-operation is checked by requiring that this same schedule and the first operation's results are unchanged.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_src_i,
  output logic [DATA_W-1:0] dvd_mag_o,
  output logic [DIV_W-1:0]  dvs_mag_o,
  output logic              q_neg_o,
  output logic              r_neg_o,
  output logic              exc_o
);
  localparam logic [DATA_W-1:0] MIN_DVD = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DIV_W-1:0] dvs;
  logic             dvd_neg, dvs_neg;

  assign dvs     = divisor_src_i[DIV_W-1:0];
  assign dvd_neg = dividend_i[DATA_W-1];
  assign dvs_neg = dvs[DIV_W-1];

  // magnitudes as unsigned; most negative values map onto themselves
  assign dvd_mag_o = dvd_neg ? (~dividend_i + 1'b1) : dividend_i;
  assign dvs_mag_o = dvs_neg ? (~dvs + 1'b1) : dvs;
  assign q_neg_o   = dvd_neg ^ dvs_neg;
  assign r_neg_o   = dvd_neg;
  assign exc_o     = (dvs == '0) || ((dividend_i == MIN_DVD) && (dvs == '1));
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] dvd_mag_i,
  input  logic [DIV_W-1:0]  dvs_mag_i,
  output logic [DATA_W-1:0] quot_mag_o,
  output logic [DIV_W-1:0]  rem_mag_o
);
  logic [DATA_W-1:0] q_r;
  logic [DIV_W-1:0]  rem_r, d_r;
  logic [DIV_W:0]    rem_sh;
  logic [DIV_W+1:0]  diff;
  logic              fits;

  assign rem_sh = {rem_r, q_r[DATA_W-1]};
  assign diff   = {1'b0, rem_sh} - {2'b00, d_r};
  assign fits   = ~diff[DIV_W+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r   <= '0;
      rem_r <= '0;
      d_r   <= '0;
    end else if (load_i) begin
      q_r   <= dvd_mag_i;
      rem_r <= '0;
      d_r   <= dvs_mag_i;
    end else if (step_i) begin
      q_r   <= {q_r[DATA_W-2:0], fits};
      rem_r <= fits ? diff[DIV_W-1:0] : rem_sh[DIV_W-1:0];
    end
  end

  assign quot_mag_o = q_r;
  assign rem_mag_o  = rem_r;

  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && d_r != '0) |=> (rem_r < d_r)); // R2
endmodule

// File: rtl/sdiv_result.sv
module sdiv_result #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fin_i,
  input  logic [DATA_W-1:0] quot_mag_i,
  input  logic [DIV_W-1:0]  rem_mag_i,
  input  logic              q_neg_i,
  input  logic              r_neg_i,
  input  logic              exc_i,
  input  logic              two_op_i,
  input  logic              same_dst_i,
  output logic [DATA_W-1:0] quot_o,
  output logic [DATA_W-1:0] rem_o,
  output logic              quot_we_o,
  output logic              rem_we_o,
  output logic              flag_we_o,
  output logic              ov_o,
  output logic              s_o,
  output logic              z_o
);
  logic [DATA_W-1:0] quot_s, rem_ext, rem_s;

  assign quot_s  = q_neg_i ? (~quot_mag_i + 1'b1) : quot_mag_i;
  assign rem_ext = {{(DATA_W-DIV_W){1'b0}}, rem_mag_i};
  assign rem_s   = r_neg_i ? (~rem_ext + 1'b1) : rem_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_o    <= '0;
      rem_o     <= '0;
      quot_we_o <= 1'b0;
      rem_we_o  <= 1'b0;
      flag_we_o <= 1'b0;
      ov_o      <= 1'b0;
      s_o       <= 1'b0;
      z_o       <= 1'b0;
    end else begin
      flag_we_o <= fin_i;
      quot_we_o <= fin_i && !exc_i && (two_op_i || !same_dst_i);
      rem_we_o  <= fin_i && !exc_i && !two_op_i;
      if (fin_i) begin
        ov_o <= exc_i;
        s_o  <= !exc_i && quot_s[DATA_W-1];
        z_o  <= !exc_i && (quot_s == '0);
        if (!exc_i) begin
          quot_o <= quot_s;
          rem_o  <= rem_s;
        end
      end
    end
  end

  AST_EXC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && exc_i) |=> (!quot_we_o && !rem_we_o && $stable(quot_o) && $stable(rem_o))); // R5
  AST_SAME_DST_REM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && !exc_i && !two_op_i && same_dst_i) |=> (rem_we_o && !quot_we_o)); // R7
  AST_FLAGS_SZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> !(s_o && z_o)); // R6
endmodule

// File: rtl/sdiv_half_unit.sv
module sdiv_half_unit
  import sdiv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_src_i,
  input  logic              two_op_i,
  input  logic              same_dst_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] quot_o,
  output logic [DATA_W-1:0] rem_o,
  output logic              quot_we_o,
  output logic              rem_we_o,
  output logic              flag_we_o,
  output logic              ov_o,
  output logic              s_o,
  output logic              z_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  sdiv_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              q_neg_q, r_neg_q, exc_q, two_op_q, same_q, done_q;
  logic              accept, step, fin;
  logic [DATA_W-1:0] dvd_mag, quot_mag;
  logic [DIV_W-1:0]  dvs_mag, rem_mag;
  logic              q_neg, r_neg, exc;

  assign accept = start_i && (state_q == ST_IDLE);
  assign step   = (state_q == ST_RUN);
  assign fin    = (state_q == ST_FIN);

  sdiv_prep #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_prep (
    .dividend_i    (dividend_i),
    .divisor_src_i (divisor_src_i),
    .dvd_mag_o     (dvd_mag),
    .dvs_mag_o     (dvs_mag),
    .q_neg_o       (q_neg),
    .r_neg_o       (r_neg),
    .exc_o         (exc)
  );

  sdiv_core #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .step_i     (step),
    .dvd_mag_i  (dvd_mag),
    .dvs_mag_i  (dvs_mag),
    .quot_mag_o (quot_mag),
    .rem_mag_o  (rem_mag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      q_neg_q  <= 1'b0;
      r_neg_q  <= 1'b0;
      exc_q    <= 1'b0;
      two_op_q <= 1'b0;
      same_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fin;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_RUN;
          cnt_q    <= '0;
          q_neg_q  <= q_neg;
          r_neg_q  <= r_neg;
          exc_q    <= exc;
          two_op_q <= two_op_i;
          same_q   <= same_dst_i;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_STEP) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sdiv_result #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_result (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fin_i      (fin),
    .quot_mag_i (quot_mag),
    .rem_mag_i  (rem_mag),
    .q_neg_i    (q_neg_q),
    .r_neg_i    (r_neg_q),
    .exc_i      (exc_q),
    .two_op_i   (two_op_q),
    .same_dst_i (same_q),
    .quot_o     (quot_o),
    .rem_o      (rem_o),
    .quot_we_o  (quot_we_o),
    .rem_we_o   (rem_we_o),
    .flag_we_o  (flag_we_o),
    .ov_o       (ov_o),
    .s_o        (s_o),
    .z_o        (z_o)
  );

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R3
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> (cnt_q <= LAST_STEP)); // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && start_i) |=> (busy_o && $stable(exc_q) && $stable(two_op_q))); // R4
  AST_WE_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quot_we_o || rem_we_o || flag_we_o) |-> done_o); // R8
  AST_DONE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> flag_we_o); // R8
endmodule

// File: tb/tb_sdiv_half_unit.sv
`timescale 1ns/1ps
module tb_sdiv_half_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [31:0] divisor_src_i = '0;
  logic        two_op_i = 1'b0;
  logic        same_dst_i = 1'b0;
  logic        busy_o, done_o, quot_we_o, rem_we_o, flag_we_o, ov_o, s_o, z_o;
  logic [31:0] quot_o, rem_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  logic [31:0] held_q = '0;
  logic [31:0] held_r = '0;

  always #2 clk_i = ~clk_i;

  sdiv_half_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_src_i(divisor_src_i),
    .two_op_i(two_op_i), .same_dst_i(same_dst_i),
    .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o), .rem_o(rem_o),
    .quot_we_o(quot_we_o), .rem_we_o(rem_we_o), .flag_we_o(flag_we_o),
    .ov_o(ov_o), .s_o(s_o), .z_o(z_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] dvd, input logic [31:0] src,
                        input bit two, input bit same, input bit inject);
    logic signed [31:0] a, d, eq, er;
    bit exc;
    logic [31:0] exp_q, exp_r;
    a = dvd;
    d = {{16{src[15]}}, src[15:0]};
    exc = (d == 0) || (a == 32'sh80000000 && d == -1);
    eq = exc ? 32'sd0 : a / d;
    er = exc ? 32'sd0 : a % d;
    @(negedge clk_i);
    dividend_i = dvd; divisor_src_i = src; two_op_i = two; same_dst_i = same;
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    dividend_i = $urandom; divisor_src_i = $urandom;
    two_op_i = ~two; same_dst_i = ~same;
    for (int i = 1; i < 32; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (inject && i == 10) begin
        start_i = 1'b1;
        dividend_i = 32'h0000_0007; divisor_src_i = 32'h0000_0000;
      end else start_i = 1'b0;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk(!done_o && busy_o, "R3 done early / busy low at edge 32", {30'b0, done_o, busy_o}, 32'h1);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(done_o && !busy_o, "R3 done at edge 33", {30'b0, done_o, busy_o}, 32'h2);
    chk(flag_we_o, "R8 flag_we with done", {31'b0, flag_we_o}, 32'h1);
    if (exc) begin
      exp_q = held_q; exp_r = held_r;
      chk({ov_o, s_o, z_o} == 3'b100, "R5 flags on overflow", {29'b0, ov_o, s_o, z_o}, 32'h4);
      chk(!quot_we_o && !rem_we_o, "R5 no writes on overflow", {30'b0, quot_we_o, rem_we_o}, 32'h0);
      chk(quot_o == exp_q && rem_o == exp_r, "R5 outputs held", quot_o ^ rem_o, exp_q ^ exp_r);
    end else begin
      exp_q = eq; exp_r = er;
      held_q = eq; held_r = er;
      chk(quot_o == exp_q, inject ? "R4 quotient after ignored start" : "R2 R1 quotient", quot_o, exp_q);
      chk(rem_o == exp_r, inject ? "R4 remainder after ignored start" : "R2 R1 remainder", rem_o, exp_r);
      chk(ov_o == 1'b0 && s_o == eq[31] && z_o == (eq == 0), "R6 flags",
          {29'b0, ov_o, s_o, z_o}, {29'b0, 1'b0, eq[31], eq == 0});
      chk({quot_we_o, rem_we_o} == (two ? 2'b10 : (same ? 2'b01 : 2'b11)), "R7 strobes",
          {30'b0, quot_we_o, rem_we_o}, {30'b0, two ? 2'b10 : (same ? 2'b01 : 2'b11)});
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk(!done_o && !flag_we_o && !quot_we_o && !rem_we_o, "R8 strobes one cycle",
        {28'b0, done_o, flag_we_o, quot_we_o, rem_we_o}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !flag_we_o && !quot_we_o && !rem_we_o && quot_o == 0 && rem_o == 0,
        "R9 reset state", {27'b0, busy_o, done_o, flag_we_o, quot_we_o, rem_we_o}, 32'h0);
    rst_ni = 1'b1;
    // directed corners
    run_op(32'd100, 32'h0000_0007, 1'b0, 1'b0, 1'b0);
    run_op(-32'sd100, 32'h0000_0007, 1'b0, 1'b0, 1'b0);
    run_op(32'd100, 32'hABCD_FFF9, 1'b0, 1'b0, 1'b0);     // R1 upper half ignored, divisor -7
    run_op(32'h8000_0000, 32'h1234_FFFF, 1'b0, 1'b0, 1'b0); // R5 min / -1
    run_op(32'h1234_5678, 32'hFFFF_0000, 1'b0, 1'b0, 1'b0); // R5 zero divisor
    run_op(32'h8000_0000, 32'h0000_8000, 1'b0, 1'b0, 1'b0);
    run_op(32'h8000_0000, 32'h0000_0001, 1'b1, 1'b0, 1'b0);
    run_op(32'h7FFF_FFFF, 32'h0000_7FFF, 1'b0, 1'b1, 1'b0);
    run_op(32'h7FFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0);
    run_op(32'd3, 32'h0000_0005, 1'b0, 1'b0, 1'b0);          // zero quotient
    run_op(32'h0000_0000, 32'h0000_8000, 1'b1, 1'b1, 1'b0);
    run_op(-32'sd12345, 32'h0000_0064, 1'b0, 1'b0, 1'b1);   // R4 start while busy
    // random
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, s;
      a = $urandom;
      s = $urandom;
      case ($urandom % 6)
        0: s[15:0] = 16'hFFFF;
        1: s[15:0] = 16'h8000;
        2: s[15:0] = 16'h7FFF;
        3: s[15:0] = 16'($urandom % 8) - 16'd4;
        default: ;
      endcase
      if ($urandom % 10 == 0) a = 32'h8000_0000;
      run_op(a, s, 1'($urandom), 1'($urandom), (k % 50) == 7);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule